// File: doc/BRIEF.md
# Write-Triggered Serial Byte Shifter

This block turns a single byte write from a processor into one complete serial transfer. It produces exactly eight clock pulses, sends the byte most significant bit first and collects eight bits from the serial input. The processor strobe can stay high for many system clocks. The block synchronises that strobe and reacts only to its rising edge. The resulting one-cycle load fills a run register with ones. Zeros then shift into the run register, one per pulse, and its top bit gates the serial clock. That top bit is why the burst always has exactly eight pulses.

When automatic mode is off at the moment of the write, the transmit byte is still loaded, but no pulses are generated. The serial clock then follows a manual level input. Each rising edge of that level samples the serial input. Each falling edge advances the transmit byte. Software can therefore drive slow transfers by hand, for example the low-rate start-up sequence of a memory card, and use the automatic burst once the card is running.

The serial clock idles low. The output data changes on falling edges and the input is captured on rising edges. The period of the automatic clock is set by a parameter that gives the length of each half-period in system clocks. The phase counter for this clock starts at the load, so the first pulse always has full width.

Top module: `spi_burst_shifter`

## Requirements
- R1: After reset the serial clock is low (with the manual level low), the busy flag and done pulse are low, the received byte is zero and the data output is zero.
- R2: A write with automatic mode on yields exactly eight rising edges of the serial clock. Every high phase lasts HALF system clocks, and every low gap between two pulses of the burst lasts HALF system clocks.
- R3: The transmit byte is loaded on the third rising system edge after the strobe rises, so bit 7 is on the data output before the first pulse. The output then presents bits 7 down to 0, one per pulse, each stable at the pulse's rising edge.
- R4: After an automatic burst, the received byte holds the serial input as sampled at the eight rising edges, with the first sample in bit 7.
- R5: A strobe held high for any number of cycles, including longer than the whole burst, produces only one burst.
- R6: A new strobe rising edge that arrives while a burst or its trailing busy cycle is in progress is ignored. The burst completes with the originally loaded byte, and no second burst follows.
- R7: A write with automatic mode off loads the transmit byte but never raises busy. The serial clock equals the manual level whenever no burst is running.
- R8: With no burst running, a rising edge of the manual level shifts the serial input into the received byte. A falling edge of the manual level advances the transmit byte by one bit.
- R9: Every transmit shift (automatic or manual) enters the fill bit at bit 0. After eight shifts, the data output equals the fill bit.
- R10: Busy rises one system clock after the load and falls one system clock after the eighth falling edge of the serial clock. Done is high for exactly that one cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe | input | 1 | Raw write strobe, may stay high for many cycles |
| auto_en | input | 1 | Automatic burst enable, sampled at the load |
| man_sclk | input | 1 | Manual serial clock level |
| fill_bit | input | 1 | Bit shifted into the transmit byte's LSB |
| tx_byte | input | W | Byte to send |
| miso | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output (transmit MSB) |
| rx_byte | output | W | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The bench builds the block with W = 8 and HALF = 2, which keeps each burst to about forty system clocks. This short burst makes a full sweep possible: every one of the 256 transmit byte values goes through an automatic burst, each paired with a different receive pattern and an alternating fill bit. Strobes held for 4, 40 and 200 cycles, and a second strobe during a burst, show that only one burst follows a write. A sweep of manual-clock transfers covers the manual path, where transmit and receive bit order are predicted from the byte values alone.

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter #(
  parameter int W    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_strobe,
  input  logic         auto_en,
  input  logic         man_sclk,
  input  logic         fill_bit,
  input  logic [W-1:0] tx_byte,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic [W-1:0] rx_byte,
  output logic         busy,
  output logic         done
);
  localparam int PW = $clog2(HALF) + 1;
  localparam logic [PW-1:0] PH_END = PW'(HALF - 1);

  logic [2:0]    wr_sync;
  logic [W-1:0]  tx_q, rx_q, run_q;
  logic [PW-1:0] ph_q;
  logic          sck_q, man_q, busy_q, done_q;

  wire burst  = run_q[W-1];
  wire load   = wr_sync[1] & ~wr_sync[2] & ~burst & ~busy_q;
  wire tick   = burst & (ph_q == PH_END);
  wire a_rise = tick & ~sck_q;
  wire a_fall = tick & sck_q;
  wire m_rise = ~burst & man_sclk & ~man_q;
  wire m_fall = ~burst & ~man_sclk & man_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sync <= '0;
      man_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      wr_sync <= {wr_sync[1:0], wr_strobe};
      man_q   <= man_sclk;
      busy_q  <= burst;
      done_q  <= busy_q & ~burst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else if (load) begin
      run_q <= auto_en ? '1 : '0;
      ph_q  <= '0;
      sck_q <= 1'b0;
    end else if (burst) begin
      ph_q  <= tick ? '0 : ph_q + 1'b1;
      if (tick) sck_q <= ~sck_q;
      if (a_fall) run_q <= {run_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else if (load) tx_q <= tx_byte;
    else if (a_fall | m_fall) tx_q <= {tx_q[W-2:0], fill_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else if (a_rise | m_rise) rx_q <= {rx_q[W-2:0], miso};
  end

  assign sclk    = burst ? sck_q : man_sclk;
  assign mosi    = tx_q[W-1];
  assign rx_byte = rx_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/spi_burst_shifter_chk.sv
module spi_burst_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic burst
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r10_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst) |=> busy);
  a_r2_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && burst) |=> sclk);
  a_r2_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst) |-> !sclk);
endmodule

bind spi_burst_shifter spi_burst_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy), .done(done), .burst(burst)
);

// File: tb/spi_burst_shifter_tb.sv
module spi_burst_shifter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, auto_en = 1'b0, man = 1'b0, fill = 1'b0;
  logic [7:0] tx = '0, pat = '0;
  logic miso, sclk, mosi, busy, done;
  logic [7:0] rx;

  int total = 0, bad = 0;
  int rises = 0, falls = 0, widthbad = 0, dones = 0, busy_hi = 0, fbase = 0;
  logic [7:0] cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = pat[7 - ((falls - fbase) & 7)];

  spi_burst_shifter #(.W(8), .HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr), .auto_en(auto_en), .man_sclk(man),
    .fill_bit(fill), .tx_byte(tx), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rx_byte(rx), .busy(busy), .done(done)
  );

  logic prev_s = 1'b0;
  int hi_len = 0, lo_len = 0, pidx = 0;
  always @(negedge clk) begin
    if (done) dones++;
    if (busy) busy_hi++;
    if (!busy) pidx = 0;
    if (sclk && !prev_s) begin
      rises++;
      cap = {cap[6:0], mosi};
      if (busy && pidx > 0 && lo_len != HALF) widthbad++;
      if (busy) pidx++;
      hi_len = 1;
    end else if (sclk) hi_len++;
    if (!sclk && prev_s) begin
      falls++;
      if (busy && hi_len != HALF) widthbad++;
      lo_len = 1;
    end else if (!sclk) lo_len++;
    prev_s = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic auto_run(input logic [7:0] d, input logic [7:0] p, input logic f,
                          input int hold, input bit rewrite);
    int rb, wb, db, t;
    @(negedge clk);
    tx = d; pat = p; fill = f; auto_en = 1'b1;
    fbase = falls; rb = rises; wb = widthbad; db = dones;
    wr = 1'b1;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (k == 3) begin
        chk(busy == 1'b0, "R10 busy before load settles", busy, 0);
        chk(mosi == d[7], "R3 bit7 after load", mosi, d[7]);
      end
      if (k == 4) chk(busy == 1'b1, "R10 busy one cycle after load", busy, 1);
    end
    wr = 1'b0;
    if (rewrite) begin
      repeat (6) @(negedge clk);
      tx = ~d; wr = 1'b1;
      repeat (3) @(negedge clk);
      wr = 1'b0;
    end
    t = 0;
    while ((busy || (rises - rb) < 8) && t < 400) begin
      @(negedge clk); t++;
    end
    repeat (8) @(negedge clk);
    chk((rises - rb) == 8, rewrite ? "R6 pulse count" : (hold > 40 ? "R5 pulse count" : "R2 pulse count"), rises - rb, 8);
    chk((widthbad - wb) == 0, "R2 phase widths", widthbad - wb, 0);
    chk(cap == d, "R3 bits out MSB first", cap, d);
    chk(rx == p, "R4 received byte", rx, p);
    chk(mosi == f, "R9 fill bit at output", mosi, f);
    chk((dones - db) == 1, "R10 one done pulse", dones - db, 1);
  endtask

  task automatic man_run(input logic [7:0] d, input logic [7:0] p, input logic f);
    int rb, bb, db;
    @(negedge clk);
    tx = d; pat = p; fill = f; auto_en = 1'b0; man = 1'b0;
    fbase = falls; rb = rises; bb = busy_hi; db = dones;
    wr = 1'b1;
    repeat (4) @(negedge clk);
    wr = 1'b0;
    repeat (6) @(negedge clk);
    chk(mosi == d[7], "R7 byte loaded without burst", mosi, d[7]);
    chk((rises - rb) == 0, "R7 no automatic pulses", rises - rb, 0);
    for (int i = 0; i < 8; i++) begin
      man = 1'b1;
      repeat (2) @(negedge clk);
      chk(sclk == 1'b1, "R7 clock follows manual level", sclk, 1);
      man = 1'b0;
      repeat (2) @(negedge clk);
    end
    chk(cap == d, "R8 manual bits out", cap, d);
    chk(rx == p, "R8 manual received byte", rx, p);
    chk(mosi == f, "R9 manual fill bit", mosi, f);
    chk((busy_hi - bb) == 0, "R7 busy never raised", busy_hi - bb, 0);
    chk((dones - db) == 0, "R7 no done pulse", dones - db, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(rx == 8'h00, "R1 reset rx", rx, 0);
    chk(mosi == 1'b0, "R1 reset mosi", mosi, 0);

    for (int v = 0; v < 256; v++)
      auto_run(8'(v), 8'(v) ^ 8'h5A ^ 8'(v << 3), v[0], 4, 1'b0);

    auto_run(8'hA5, 8'h3C, 1'b1, 40, 1'b0);
    auto_run(8'h81, 8'hE7, 1'b0, 200, 1'b0);
    auto_run(8'hC3, 8'h18, 1'b1, 4, 1'b1);
    auto_run(8'h0F, 8'hF0, 1'b0, 4, 1'b1);

    for (int v = 0; v < 16; v++)
      man_run(8'(v * 37 + 11), 8'(v * 53 + 7), v[1]);

    auto_run(8'h96, 8'h69, 1'b1, 4, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule